// File: doc/BRIEF.md
# Clock Source Select Controller

This controller holds the source choice for four clock domains: acquisition, generation, auxiliary I/O and a global clock. Each choice is a small code. Software-side logic presents all four requested codes and pulses a write input. On the rising edge of that input the controller checks the request. If the request is legal, the controller commits it and signals through a ready output that the external crosspoint device is busy. An illegal request is refused as a whole, and the refusal is recorded.

The legal codes are 0 for an undriven output, 2 for the backplane clock, 3 for the on-board oscillator and 4 for the strobe routed through the crosspoint. Code 5, the strobe taken on the direct path around the crosspoint, is allowed only on the acquisition source. While acquisition uses code 5, no other source may use code 4. The block runs on the 40 MHz configuration clock. The serial programming of the physical switch is modelled as a busy period of fixed length.

Top module: `clksel_ctrl`

## Requirements
- R1: After reset all four committed source outputs read 0 (undriven), the ready output is 1 and the error flag is 0.
- R2: A request whose four codes are each one of 0, 2, 3 or 4 is committed on the clock edge that samples a rising edge of the write input while ready is 1. The new values appear on the outputs after that edge.
- R3: Code 5 is accepted and committed on the acquisition source.
- R4: A request is rejected if any source carries code 1, 6 or 7, or if the generation, auxiliary or global source carries code 5.
- R5: A request is rejected if the acquisition source carries code 5 and any of the other three sources carries code 4.
- R6: A rejected request leaves all committed outputs unchanged and keeps ready at 1. It sets the error flag, which then stays 1 until reset.
- R7: Only a rising edge of the write input acts. Holding the write input high commits once, and later changes to the requested codes during the hold have no effect.
- R8: After an accepted request, ready is 0 for exactly BUSY_CYCLES clock cycles (default 64) and then returns to 1.
- R9: A rising edge of the write input that arrives while ready is 0 is ignored. It commits nothing and does not set the error flag, even when its codes are illegal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| cfgClk | input | 1 | 40 MHz configuration clock |
| rstN | input | 1 | Asynchronous active-low reset |
| acqSelIn | input | SEL_W | Requested acquisition source code |
| genSelIn | input | SEL_W | Requested generation source code |
| auxSelIn | input | SEL_W | Requested auxiliary I/O source code |
| globSelIn | input | SEL_W | Requested global clock source code |
| commitReq | input | 1 | Write input; its rising edge requests a commit |
| readyOut | output | 1 | 1 when a new request may be issued |
| errFlag | output | 1 | Sticky flag set by a rejected request |
| acqSelOut | output | SEL_W | Committed acquisition source code |
| genSelOut | output | SEL_W | Committed generation source code |
| auxSelOut | output | SEL_W | Committed auxiliary I/O source code |
| globSelOut | output | SEL_W | Committed global clock source code |

## Verification
The bench builds the controller with SEL_W at its default of 3 and BUSY_CYCLES set to 8. With a 3-bit code, every code from 0 to 7 can be driven on every source, so each illegal value and the bypass conflict are reached directly. With the short busy window, the bench can count the exact cycle on which ready returns and can place write edges inside the window. It can also hold the write input high across the end of the window.

// File: rtl/clksel_pkg.sv
package clksel_pkg;

  // number of clock domains whose source is selected
  localparam int NUM_SRC   = 4;
  localparam int SEL_W_DEF = 3;

  // position of each domain in the internal selection array
  localparam int IDX_ACQ  = 0;
  localparam int IDX_GEN  = 1;
  localparam int IDX_AUX  = 2;
  localparam int IDX_GLOB = 3;

  // source codes; the external switch decodes these values
  localparam int SRC_OFF    = 0;
  localparam int SRC_BKPL   = 2;
  localparam int SRC_OSC    = 3;
  localparam int SRC_XSTRB  = 4;
  localparam int SRC_BYPASS = 5;

  // strobes from the control path to the datapath
  typedef struct packed {
    logic capture;  // commit the requested selections
    logic flagErr;  // record a rejected request
  } clksel_strobe_t;

endpackage

// File: rtl/clksel_datapath.sv
module clksel_datapath
  import clksel_pkg::*;
#(
  parameter int SEL_W = SEL_W_DEF
) (
  input  logic                            clk,
  input  logic                            rstN,
  input  logic [NUM_SRC-1:0][SEL_W-1:0]   reqSel,
  input  clksel_strobe_t                  stb,
  output logic                            reqLegal,
  output logic [NUM_SRC-1:0][SEL_W-1:0]   curSel,
  output logic                            errSticky
);

  logic [NUM_SRC-1:0] chanOk;
  logic [NUM_SRC-1:1] usesXstrb;
  logic               acqBypass;
  logic               bypassClash;

  // per-source code check; only acquisition may use the bypass code
  for (genvar i = 0; i < NUM_SRC; i++) begin : g_chk
    logic baseOk;
    assign baseOk = (reqSel[i] == SEL_W'(SRC_OFF))  ||
                    (reqSel[i] == SEL_W'(SRC_BKPL)) ||
                    (reqSel[i] == SEL_W'(SRC_OSC))  ||
                    (reqSel[i] == SEL_W'(SRC_XSTRB));
    if (i == IDX_ACQ) begin : g_acq
      assign chanOk[i] = baseOk || (reqSel[i] == SEL_W'(SRC_BYPASS));
    end else begin : g_other
      assign chanOk[i]    = baseOk;
      assign usesXstrb[i] = (reqSel[i] == SEL_W'(SRC_XSTRB));
    end
  end

  // the direct strobe path and the crosspoint strobe exclude each other
  assign acqBypass   = (reqSel[IDX_ACQ] == SEL_W'(SRC_BYPASS));
  assign bypassClash = acqBypass && (|usesXstrb);
  assign reqLegal    = (&chanOk) && !bypassClash;

  // committed selections, one register per domain
  for (genvar i = 0; i < NUM_SRC; i++) begin : g_reg
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        curSel[i] <= SEL_W'(SRC_OFF);
      end else if (stb.capture) begin
        curSel[i] <= reqSel[i];
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      errSticky <= 1'b0;
    end else if (stb.flagErr) begin
      errSticky <= 1'b1;
    end
  end

endmodule

// File: rtl/clksel_control.sv
module clksel_control
  import clksel_pkg::*;
#(
  parameter int BUSY_CYCLES = 64
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic           writeIn,
  input  logic           legalIn,
  output clksel_strobe_t stb,
  output logic           readyOut
);

  localparam int CNT_W = $clog2(BUSY_CYCLES + 1);

  logic             reqQ;
  logic             writeEdge;
  logic             idle;
  logic [CNT_W-1:0] busyCnt;

  // reset to 1 so a level already high at reset release is not an edge
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) reqQ <= 1'b1;
    else       reqQ <= writeIn;
  end

  assign writeEdge = writeIn && !reqQ;
  assign idle      = (busyCnt == '0);
  assign readyOut  = idle;

  always_comb begin
    stb         = '0;
    stb.capture = writeEdge && idle && legalIn;
    stb.flagErr = writeEdge && idle && !legalIn;
  end

  // counts down the time the external switch needs for a commit
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busyCnt <= '0;
    end else if (stb.capture) begin
      busyCnt <= CNT_W'(BUSY_CYCLES);
    end else if (!idle) begin
      busyCnt <= busyCnt - 1'b1;
    end
  end

endmodule

// File: rtl/clksel_ctrl.sv
module clksel_ctrl
  import clksel_pkg::*;
#(
  parameter int SEL_W       = SEL_W_DEF,
  parameter int BUSY_CYCLES = 64
) (
  input  logic             cfgClk,
  input  logic             rstN,
  input  logic [SEL_W-1:0] acqSelIn,
  input  logic [SEL_W-1:0] genSelIn,
  input  logic [SEL_W-1:0] auxSelIn,
  input  logic [SEL_W-1:0] globSelIn,
  input  logic             commitReq,
  output logic             readyOut,
  output logic             errFlag,
  output logic [SEL_W-1:0] acqSelOut,
  output logic [SEL_W-1:0] genSelOut,
  output logic [SEL_W-1:0] auxSelOut,
  output logic [SEL_W-1:0] globSelOut
);

  logic [NUM_SRC-1:0][SEL_W-1:0] reqSel;
  logic [NUM_SRC-1:0][SEL_W-1:0] curSel;
  clksel_strobe_t                stb;
  logic                          reqLegal;

  assign reqSel[IDX_ACQ]  = acqSelIn;
  assign reqSel[IDX_GEN]  = genSelIn;
  assign reqSel[IDX_AUX]  = auxSelIn;
  assign reqSel[IDX_GLOB] = globSelIn;

  clksel_control #(
    .BUSY_CYCLES(BUSY_CYCLES)
  ) u_ctrl (
    .clk     (cfgClk),
    .rstN    (rstN),
    .writeIn (commitReq),
    .legalIn (reqLegal),
    .stb     (stb),
    .readyOut(readyOut)
  );

  clksel_datapath #(
    .SEL_W(SEL_W)
  ) u_dp (
    .clk      (cfgClk),
    .rstN     (rstN),
    .reqSel   (reqSel),
    .stb      (stb),
    .reqLegal (reqLegal),
    .curSel   (curSel),
    .errSticky(errFlag)
  );

  assign acqSelOut  = curSel[IDX_ACQ];
  assign genSelOut  = curSel[IDX_GEN];
  assign auxSelOut  = curSel[IDX_AUX];
  assign globSelOut = curSel[IDX_GLOB];

endmodule

// File: rtl/clksel_ctrl_chk.sv
module clksel_ctrl_chk #(
  parameter int SEL_W       = 3,
  parameter int BUSY_CYCLES = 64
) (
  input logic             cfgClk,
  input logic             rstN,
  input logic             readyOut,
  input logic             errFlag,
  input logic [SEL_W-1:0] acqSelOut,
  input logic [SEL_W-1:0] genSelOut,
  input logic [SEL_W-1:0] auxSelOut,
  input logic [SEL_W-1:0] globSelOut
);

  logic [4*SEL_W-1:0] allSel;
  int                 lowCnt;

  assign allSel = {acqSelOut, genSelOut, auxSelOut, globSelOut};

  // length of the current low stretch of ready
  always_ff @(posedge cfgClk or negedge rstN) begin
    if (!rstN)          lowCnt <= 0;
    else if (!readyOut) lowCnt <= lowCnt + 1;
    else                lowCnt <= 0;
  end

  // R8
  busy_len_chk: assert property (@(posedge cfgClk) disable iff (!rstN)
    $rose(readyOut) |-> (lowCnt == BUSY_CYCLES));

  // R2
  commit_busy_chk: assert property (@(posedge cfgClk) disable iff (!rstN)
    (allSel != $past(allSel)) |-> $fell(readyOut));

  // R6
  err_sticky_chk: assert property (@(posedge cfgClk) disable iff (!rstN)
    errFlag |=> errFlag);

  // R6
  reject_hold_chk: assert property (@(posedge cfgClk) disable iff (!rstN)
    $rose(errFlag) |-> ($stable(allSel) && readyOut));

  // R9
  busy_quiet_chk: assert property (@(posedge cfgClk) disable iff (!rstN)
    !readyOut |=> ($stable(allSel) && $stable(errFlag)));

  // R4
  bypass_only_acq_chk: assert property (@(posedge cfgClk) disable iff (!rstN)
    (genSelOut != SEL_W'(5)) && (auxSelOut != SEL_W'(5)) && (globSelOut != SEL_W'(5)));

  // R5
  no_clash_chk: assert property (@(posedge cfgClk) disable iff (!rstN)
    (acqSelOut == SEL_W'(5)) |->
      ((genSelOut != SEL_W'(4)) && (auxSelOut != SEL_W'(4)) && (globSelOut != SEL_W'(4))));

endmodule

bind clksel_ctrl clksel_ctrl_chk #(
  .SEL_W      (SEL_W),
  .BUSY_CYCLES(BUSY_CYCLES)
) u_chk (
  .cfgClk    (cfgClk),
  .rstN      (rstN),
  .readyOut  (readyOut),
  .errFlag   (errFlag),
  .acqSelOut (acqSelOut),
  .genSelOut (genSelOut),
  .auxSelOut (auxSelOut),
  .globSelOut(globSelOut)
);

// File: tb/sim_clksel_ctrl.sv
`timescale 1ns/1ps
module sim_clksel_ctrl;

  localparam int SEL_W   = 3;
  localparam int TB_BUSY = 8;
  localparam int NVEC    = 12;

  logic             cfgClk = 1'b0;
  logic             rstN;
  logic [SEL_W-1:0] acqSelIn, genSelIn, auxSelIn, globSelIn;
  logic             commitReq;
  logic             readyOut, errFlag;
  logic [SEL_W-1:0] acqSelOut, genSelOut, auxSelOut, globSelOut;

  int compared   = 0;
  int mismatched = 0;
  int cycles     = 0;

  clksel_ctrl #(.SEL_W(SEL_W), .BUSY_CYCLES(TB_BUSY)) u0 (
    .cfgClk(cfgClk), .rstN(rstN),
    .acqSelIn(acqSelIn), .genSelIn(genSelIn), .auxSelIn(auxSelIn), .globSelIn(globSelIn),
    .commitReq(commitReq), .readyOut(readyOut), .errFlag(errFlag),
    .acqSelOut(acqSelOut), .genSelOut(genSelOut), .auxSelOut(auxSelOut), .globSelOut(globSelOut)
  );

  always #10 cfgClk = ~cfgClk;

  // {acq, gen, aux, glob, accepted}
  localparam logic [12:0] VEC [NVEC] = '{
    {3'd2, 3'd3, 3'd4, 3'd0, 1'b1},
    {3'd5, 3'd2, 3'd3, 3'd0, 1'b1},
    {3'd5, 3'd4, 3'd0, 3'd0, 1'b0},
    {3'd3, 3'd5, 3'd0, 3'd0, 1'b0},
    {3'd1, 3'd0, 3'd0, 3'd0, 1'b0},
    {3'd4, 3'd4, 3'd4, 3'd4, 1'b1},
    {3'd5, 3'd0, 3'd0, 3'd4, 1'b0},
    {3'd5, 3'd3, 3'd2, 3'd2, 1'b1},
    {3'd0, 3'd0, 3'd6, 3'd0, 1'b0},
    {3'd0, 3'd0, 3'd0, 3'd7, 1'b0},
    {3'd2, 3'd2, 3'd2, 3'd2, 1'b1},
    {3'd0, 3'd0, 3'd5, 3'd0, 1'b0}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [11:0] outs();
    return {acqSelOut, genSelOut, auxSelOut, globSelOut};
  endfunction

  task automatic finishRun();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  task automatic doReset();
    rstN = 1'b0; commitReq = 1'b0;
    {acqSelIn, genSelIn, auxSelIn, globSelIn} = '0;
    repeat (3) @(negedge cfgClk);
    rstN = 1'b1;
    repeat (2) @(negedge cfgClk);
  endtask

  // one write pulse; returns at the negedge after the sampling edge
  task automatic doWrite(input logic [11:0] codes);
    {acqSelIn, genSelIn, auxSelIn, globSelIn} = codes;
    commitReq = 1'b1;
    @(negedge cfgClk);
    commitReq = 1'b0;
  endtask

  task automatic waitReady(output int lowSeen);
    lowSeen = 0;
    while (!readyOut && lowSeen < 1000) begin
      lowSeen++;
      @(negedge cfgClk);
    end
    @(negedge cfgClk);
  endtask

  initial begin
    forever begin
      @(posedge cfgClk);
      cycles++;
      if (cycles > 20000) begin
        mismatched++;
        $display("FAIL watchdog: actual %0d expected <= 20000", cycles);
        finishRun();
      end
    end
  end

  initial begin
    logic [11:0] expOuts;
    int lowSeen;

    doReset();
    // R1 reset state
    check("R1 outputs", 32'(outs()), 32'd0);
    check("R1 ready", 32'(readyOut), 32'd1);
    check("R1 err", 32'(errFlag), 32'd0);

    // R9: edges during busy, legal and illegal, are ignored
    doWrite({3'd3, 3'd2, 3'd0, 3'd4});
    check("R2 commit", 32'(outs()), 32'({3'd3, 3'd2, 3'd0, 3'd4}));
    check("R8 ready low", 32'(readyOut), 32'd0);
    doWrite({3'd2, 3'd2, 3'd2, 3'd2});
    @(negedge cfgClk);
    doWrite({3'd1, 3'd5, 3'd6, 3'd7});
    waitReady(lowSeen);
    check("R9 outputs", 32'(outs()), 32'({3'd3, 3'd2, 3'd0, 3'd4}));
    check("R9 err", 32'(errFlag), 32'd0);

    // R6: first rejection sets flag, outputs and ready untouched
    doWrite({3'd5, 3'd0, 3'd4, 3'd0});
    check("R6 outputs", 32'(outs()), 32'({3'd3, 3'd2, 3'd0, 3'd4}));
    check("R6 ready", 32'(readyOut), 32'd1);
    check("R6 err set", 32'(errFlag), 32'd1);
    expOuts = outs();
    @(negedge cfgClk);

    // table: R2 R3 R4 R5 R8
    for (int i = 0; i < NVEC; i++) begin
      doWrite(VEC[i][12:1]);
      if (VEC[i][0]) begin
        expOuts = VEC[i][12:1];
        check("R2/R3 commit", 32'(outs()), 32'(expOuts));
        waitReady(lowSeen);
        check("R8 busy length", 32'(lowSeen), 32'(TB_BUSY));
      end else begin
        check("R4/R5 reject outputs", 32'(outs()), 32'(expOuts));
        check("R4/R5 reject ready", 32'(readyOut), 32'd1);
        @(negedge cfgClk);
      end
    end
    check("R6 err sticky", 32'(errFlag), 32'd1);

    // R7: a held write commits once only
    {acqSelIn, genSelIn, auxSelIn, globSelIn} = {3'd4, 3'd0, 3'd3, 3'd2};
    commitReq = 1'b1;
    @(negedge cfgClk);
    check("R7 first commit", 32'(outs()), 32'({3'd4, 3'd0, 3'd3, 3'd2}));
    waitReady(lowSeen);
    {acqSelIn, genSelIn, auxSelIn, globSelIn} = {3'd0, 3'd3, 3'd3, 3'd3};
    repeat (3) @(negedge cfgClk);
    check("R7 held level", 32'(outs()), 32'({3'd4, 3'd0, 3'd3, 3'd2}));
    check("R7 ready", 32'(readyOut), 32'd1);
    commitReq = 1'b0;
    @(negedge cfgClk);

    // R1 again after a second reset clears the sticky flag
    doReset();
    check("R1 err cleared", 32'(errFlag), 32'd0);
    check("R1 outputs again", 32'(outs()), 32'd0);

    finishRun();
  end

endmodule